// File: doc/BRIEF.md
# Dual-Channel Even Clock Divider with Synchronous Stop

This block derives two clock outputs from one fast source clock. Channel A divides the source by an even ratio picked with a 3-bit code. Every ratio has a 50% duty cycle, and the set includes /6 and /12 as well as powers of two. Channel B either copies channel A or runs at half of A's rate, chosen by one select bit. In half-rate mode, each rising edge of B falls on a rising edge of A.

Each channel has its own active-low stop input. A stop input is synchronized into the source clock domain. It only takes hold while its output is low, so a stopped output parks low and a restarted output begins with a full-width high phase. The divider counters keep running while an output is stopped. Because of that, restarting a channel puts it back on the same phase grid, and A and B stay aligned after any sequence of stops and starts.

An active-low master reset clears the counters and forces both outputs low at once, even in the middle of a pulse.

Top module: `clk_div_stop`

## Requirements
- R1: The ratio code maps as follows: 3'b000 gives /2, 3'b100 gives /4, 3'b101 gives /6, 3'b010 gives /8, 3'b011 gives /12, 3'b110 gives /16 and 3'b001 gives /32. The spare code 3'b111 behaves as /2.
- R2: For every ratio N, out_a is high for N/2 source cycles and low for N/2 source cycles.
- R3: With half_b low, out_b equals out_a in every cycle while both channels run.
- R4: With half_b high, out_b is high for N cycles and low for N cycles, and every rising edge of out_b coincides with a rising edge of out_a.
- R5: While a stop input is held low, its output stays low once the synchronizer delay and the current period have passed. A high phase already under way completes at full width, and no high pulse shorter than N/2 cycles appears.
- R6: After a stop input returns high, the first high phase of that output has full width.
- R7: The two stop inputs act independently: stopping one channel leaves the other toggling.
- R8: After independent stops and restarts of both channels, the rising edges of out_b still coincide with rising edges of out_a.
- R9: rst_n low forces out_a and out_b low at once, without waiting for a clock edge, even mid-pulse. Both outputs are low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| ratio_sel | input | 3 | Channel A division code |
| half_b | input | 1 | 1: channel B at half of A's rate; 0: B equals A |
| stop_a_n | input | 1 | Active-low stop request for channel A |
| stop_b_n | input | 1 | Active-low stop request for channel B |
| out_a | output | 1 | Channel A clock output |
| out_b | output | 1 | Channel B clock output |

## Verification
The pulse-width and phase properties assume that ratio_sel and half_b have been steady for a settling window before any edge they judge. A ratio change mid-period legitimately yields one odd-width phase. The stop inputs may change at any time and need no such assumption.

The stimulus honours the settling window in two ways. Ratio and mode changes happen only while the bench's own width and alignment monitors are disarmed. Each change is then followed by several full output periods before measuring resumes.

// File: rtl/clk_div_stop.sv
module clk_div_stop #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       vco_clk,
  input  logic       rst_n,
  input  logic [2:0] ratio_sel,
  input  logic       half_b,
  input  logic       stop_a_n,
  input  logic       stop_b_n,
  output logic       out_a,
  output logic       out_b
);
  localparam int CW = 4;

  logic [CW-1:0]          cnt, half_m1, cnt_n;
  logic [1:0]             phase, phase_n;
  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic                   en_a, en_b, en_a_n, en_b_n;
  logic                   wrap, wave_a, wave_b;

  always_comb begin
    case (ratio_sel)
      3'b000:  half_m1 = CW'(0);
      3'b001:  half_m1 = CW'(15);
      3'b010:  half_m1 = CW'(3);
      3'b011:  half_m1 = CW'(5);
      3'b100:  half_m1 = CW'(1);
      3'b101:  half_m1 = CW'(2);
      3'b110:  half_m1 = CW'(7);
      default: half_m1 = CW'(0);
    endcase
  end

  assign wrap    = cnt >= half_m1;
  assign cnt_n   = wrap ? '0 : cnt + 1'b1;
  assign phase_n = wrap ? phase + 1'b1 : phase;
  assign wave_a  = phase_n[0];
  assign wave_b  = half_b ? (phase_n[1] ^ phase_n[0]) : phase_n[0];
  assign en_a_n  = wave_a ? en_a : sync_a[SYNC_STAGES-1];
  assign en_b_n  = wave_b ? en_b : sync_b[SYNC_STAGES-1];

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      phase  <= '0;
      sync_a <= '0;
      sync_b <= '0;
      en_a   <= 1'b0;
      en_b   <= 1'b0;
      out_a  <= 1'b0;
      out_b  <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      phase  <= phase_n;
      sync_a <= {sync_a[SYNC_STAGES-2:0], stop_a_n};
      sync_b <= {sync_b[SYNC_STAGES-2:0], stop_b_n};
      en_a   <= en_a_n;
      en_b   <= en_b_n;
      out_a  <= wave_a & en_a_n;
      out_b  <= wave_b & en_b_n;
    end
  end
endmodule

// File: rtl/clk_div_stop_chk.sv
module clk_div_stop_chk (
  input logic       vco_clk,
  input logic       rst_n,
  input logic [2:0] ratio_sel,
  input logic       half_b,
  input logic       stop_a_n,
  input logic       stop_b_n,
  input logic       out_a,
  input logic       out_b,
  input logic [1:0] phase
);
  logic [5:0] h;
  logic [6:0] wb, hi_a, hi_b, quiet;
  logic [7:0] lo_a, lo_b, park;
  logic [2:0] prev_sel;
  logic       prev_half;

  always_comb begin
    case (ratio_sel)
      3'b001:  h = 6'd16;
      3'b010:  h = 6'd4;
      3'b011:  h = 6'd6;
      3'b100:  h = 6'd2;
      3'b101:  h = 6'd3;
      3'b110:  h = 6'd8;
      default: h = 6'd1;
    endcase
  end

  assign wb   = half_b ? {h, 1'b0} : {1'b0, h};
  assign park = {1'b0, wb, 1'b0} + 8'd8;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_a <= '0; hi_b <= '0; lo_a <= '0; lo_b <= '0;
      quiet <= '0; prev_sel <= '0; prev_half <= 1'b0;
    end else begin
      prev_sel  <= ratio_sel;
      prev_half <= half_b;
      if (prev_sel != ratio_sel || prev_half != half_b) quiet <= '0;
      else if (quiet < 7'd100) quiet <= quiet + 1'b1;
      hi_a <= out_a ? ((hi_a < 7'd100) ? hi_a + 1'b1 : hi_a) : '0;
      hi_b <= out_b ? ((hi_b < 7'd100) ? hi_b + 1'b1 : hi_b) : '0;
      lo_a <= stop_a_n ? '0 : ((lo_a < 8'd200) ? lo_a + 1'b1 : lo_a);
      lo_b <= stop_b_n ? '0 : ((lo_b < 8'd200) ? lo_b + 1'b1 : lo_b);
    end
  end

  a_r2_full_high_a: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $fell(out_a) && quiet >= 7'd70 |-> hi_a == {1'b0, h});

  a_r4_full_high_b: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $fell(out_b) && quiet >= 7'd70 |-> hi_b == wb);

  a_r8_b_rise_on_a_grid: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $rose(out_b) && quiet >= 7'd2 |-> phase[0] && !$past(phase[0]));

  a_r5_park_low_a: assert property (@(posedge vco_clk) disable iff (!rst_n)
    lo_a > park && quiet >= 7'd70 |-> !out_a);

  a_r5_park_low_b: assert property (@(posedge vco_clk) disable iff (!rst_n)
    lo_b > park && quiet >= 7'd70 |-> !out_b);
endmodule

bind clk_div_stop clk_div_stop_chk i_chk (.*);

// File: tb/test_clk_div_stop.sv
module test_clk_div_stop;
  localparam int CLK_PERIOD = 10;

  logic       vco_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_sel = 3'b000;
  logic       half_b = 1'b0;
  logic       stop_a_n = 1'b1;
  logic       stop_b_n = 1'b1;
  logic       out_a, out_b;

  int checks = 0, errors = 0;
  bit runt_on = 0, align_on = 0;
  int exp_ha = 1, exp_hb = 1;
  int ra = -1000, rb = -1000, runts = 0, align_err = 0, b_rises = 0;
  logic pa = 1'b0, pb = 1'b0;

  clk_div_stop i_clk_div_stop (.*);

  always #(CLK_PERIOD/2) vco_clk = ~vco_clk;

  always @(negedge vco_clk) begin
    if (runt_on) begin
      if (out_a) ra++;
      else begin
        if (pa && ra > 0 && ra != exp_ha) runts++;
        ra = 0;
      end
      if (out_b) rb++;
      else begin
        if (pb && rb > 0 && rb != exp_hb) runts++;
        rb = 0;
      end
    end else begin
      ra = -1000;
      rb = -1000;
    end
    if (align_on && out_b && !pb) begin
      b_rises++;
      if (!(out_a && !pa)) align_err++;
    end
    pa = out_a;
    pb = out_b;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge vco_clk);
  endtask

  function automatic logic pick(input bit b);
    return b ? out_b : out_a;
  endfunction

  task automatic measure(input bit b, output int hi, output int lo);
    int g = 0;
    while (pick(b) !== 1'b0 && g < 500) begin step(1); g++; end
    while (pick(b) !== 1'b1 && g < 1000) begin step(1); g++; end
    hi = 0;
    while (pick(b) === 1'b1 && hi < 500) begin hi++; step(1); end
    lo = 0;
    while (pick(b) === 1'b0 && lo < 500) begin lo++; step(1); end
  endtask

  function automatic int ratio_of(input logic [2:0] c);
    case (c)
      3'b001: return 32;
      3'b010: return 8;
      3'b011: return 12;
      3'b100: return 4;
      3'b101: return 6;
      3'b110: return 16;
      default: return 2;
    endcase
  endfunction

  task automatic t_reset_state;
    step(3);
    check(out_a == 1'b0 && out_b == 1'b0, "R9 outputs low in reset", {out_a, out_b}, 0);
    rst_n = 1'b1;
    step(1);
    check(out_a == 1'b0 && out_b == 1'b0, "R9 outputs low after release", {out_a, out_b}, 0);
  endtask

  task automatic t_ratios;
    int hi, lo;
    for (int c = 0; c < 8; c++) begin
      ratio_sel = 3'(c);
      step(80);
      measure(1'b0, hi, lo);
      check(hi == ratio_of(3'(c)) / 2, $sformatf("R1 high width code %0d", c), hi, ratio_of(3'(c)) / 2);
      check(lo == hi, $sformatf("R2 duty code %0d", c), lo, hi);
    end
  endtask

  task automatic t_same;
    int mism = 0;
    ratio_sel = 3'b101;
    half_b = 1'b0;
    step(40);
    for (int i = 0; i < 60; i++) begin
      if (out_b !== out_a) mism++;
      step(1);
    end
    check(mism == 0, "R3 B equals A", mism, 0);
  endtask

  task automatic t_half;
    int hi, lo;
    ratio_sel = 3'b100;
    half_b = 1'b1;
    step(40);
    measure(1'b1, hi, lo);
    check(hi == 4 && lo == 4, "R4 half-rate B width", hi * 100 + lo, 404);
    align_err = 0; b_rises = 0; align_on = 1;
    step(100);
    align_on = 0;
    check(align_err == 0 && b_rises > 5, "R4 B rises on A rises", align_err, 0);
  endtask

  task automatic t_stop;
    int hi, lo, highs = 0, b_tog = 0, mism = 0;
    ratio_sel = 3'b010;
    half_b = 1'b0;
    exp_ha = 4; exp_hb = 4;
    step(40);
    runts = 0; runt_on = 1;
    while (out_a !== 1'b1) step(1);
    step(1);
    stop_a_n = 1'b0;
    step(30);
    for (int i = 0; i < 32; i++) begin
      if (out_a) highs++;
      if (out_b != pb) b_tog++;
      step(1);
    end
    check(highs == 0, "R5 A parked low", highs, 0);
    check(b_tog > 4, "R7 B keeps running while A stopped", b_tog, 8);
    stop_a_n = 1'b1;
    measure(1'b0, hi, lo);
    check(hi == 4, "R6 first pulse after restart full width", hi, 4);
    step(20);
    for (int i = 0; i < 40; i++) begin
      if (out_a !== out_b) mism++;
      step(1);
    end
    check(mism == 0, "R8 A back in phase with B", mism, 0);
    step(3);
    stop_b_n = 1'b0;
    step(40);
    highs = 0; b_tog = 0;
    for (int i = 0; i < 32; i++) begin
      if (out_b) highs++;
      if (out_a != pa) b_tog++;
      step(1);
    end
    check(highs == 0 && b_tog > 4, "R7 A runs while B stopped", highs * 100 + b_tog, 8);
    stop_b_n = 1'b1;
    step(40);
    runt_on = 0;
    check(runts == 0, "R5 no runt pulses", runts, 0);
  endtask

  task automatic t_align;
    ratio_sel = 3'b101;
    half_b = 1'b1;
    exp_ha = 3; exp_hb = 6;
    step(60);
    runts = 0; runt_on = 1;
    step(2); stop_b_n = 1'b0;
    step(7); stop_a_n = 1'b0;
    step(23); stop_b_n = 1'b1;
    step(11); stop_a_n = 1'b1;
    step(5); stop_b_n = 1'b0;
    step(17); stop_b_n = 1'b1;
    step(40);
    align_err = 0; b_rises = 0; align_on = 1;
    step(120);
    align_on = 0;
    runt_on = 0;
    check(align_err == 0 && b_rises > 5, "R8 alignment after stop/start", align_err, 0);
    check(runts == 0, "R5 no runt in half mode", runts, 0);
  endtask

  task automatic t_reset_mid;
    ratio_sel = 3'b001;
    half_b = 1'b0;
    step(80);
    while (out_a !== 1'b1) step(1);
    step(3);
    #2 rst_n = 1'b0;
    #1 check(out_a == 1'b0 && out_b == 1'b0, "R9 async clear mid-pulse", {out_a, out_b}, 0);
    step(4);
    check(out_a == 1'b0 && out_b == 1'b0, "R9 held low in reset", {out_a, out_b}, 0);
    rst_n = 1'b1;
    step(1);
    check(out_a == 1'b0, "R9 low after release", out_a, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_ratios();
    t_same();
    t_half();
    t_stop();
    t_align();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule